// File: doc/BRIEF.md
# SPI TPM FIFO Transaction Master

This block carries out one register access to a TPM-style target on an SPI bus. The host side gives a single-cycle start pulse together with the direction, a 16-bit register address, a byte count and a flat write-data vector. The master drops chip select and sends a four-byte command header. It then keeps chip select low and clocks single poll bytes until the target marks itself ready in bit 0 of a received byte. Only after that does it move the data bytes. When the access ends it gives a one-cycle done pulse with a two-bit status.

The bus runs in SPI mode 0 with the most significant bit first. SCLK idles low and MOSI is valid before each rising edge. The master samples MISO on the rising edge and shifts MOSI after the falling edge. The half period of SCLK, the largest byte count and the number of poll bytes allowed before giving up are all parameters. Wake-up handling and the spacing between accesses are done by a separate gate ahead of this block.

Top module: `spi_tpm_fifo_master`

## Requirements
- R1: Header byte 0 is {dir, 0, count-1}. Bit 7 is 1 for a read and 0 for a write, bit 6 is 0, and bits 5:0 hold the byte count minus one.
- R2: Header byte 1 is 0xD4. Byte 2 is address bits 15:8 and byte 3 is address bits 7:0. Every byte goes out MSB first in mode 0: MOSI does not change while SCLK is high.
- R3: A request with a count of 0 or above MAX_LEN (64) gives done on the next cycle with status 1 (length error). Chip select is never asserted and SCLK never toggles.
- R4: Chip select falls once before the first SCLK edge of an access and rises once, after the last byte. It never goes high in between, and SCLK is only high while chip select is low.
- R5: After the header the master clocks poll bytes with MOSI at 0x00. It repeats until a received poll byte has bit 0 set, and only then starts the data phase.
- R6: Bit 0 of the bytes received during the header is ignored. Poll bytes always follow the header, even when the target returns 0x01 there.
- R7: If MAX_POLLS poll bytes in a row arrive without bit 0 set, the access ends with status 2 (timeout). Chip select is released and no data byte is clocked. A ready flag on the last allowed poll byte still proceeds with status 0.
- R8: On a read, the k-th data byte received lands in rd_data bits [8k+7:8k]. During the read data phase MOSI is 0x00, and the access ends with status 0.
- R9: On a write, MOSI carries wr_data bits [8k+7:8k] as the k-th data byte. MISO is ignored during the write data phase, and the access ends with status 0.
- R10: busy is high from the cycle after an accepted start until done, and done comes only while busy is low. A start pulse while busy has no effect.
- R11: After reset cs_n is 1, sclk is 0, busy is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request pulse |
| is_read | input | 1 | 1 = read access, 0 = write access |
| addr | input | 16 | Register address |
| len | input | LEN_W (7) | Byte count, valid range 1..MAX_LEN |
| wr_data | input | MAX_LEN*8 | Write bytes, byte k at bits [8k+7:8k] |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 length error, 2 timeout |
| rd_data | output | MAX_LEN*8 | Read bytes, byte k at bits [8k+7:8k] |
| sclk | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | Data to target |
| miso | input | 1 | Data from target |

## Verification
The hardest cases to reach from the ports are the two edges of the poll window. One is ready arriving on exactly the last allowed poll byte. The other is ready never arriving, so the access times out with chip select released and no data clocked. The bench drives these with a target model that returns a programmed number of not-ready bytes after the header and then a ready byte. The model also sets bit 0 in its header responses, so any access that reads flow control during the header shows up as a wrong byte count on the bus.

// File: rtl/spi_tpm_pkg.sv
package spi_tpm_pkg;

    typedef enum logic [1:0] {
        XS_OK      = 2'd0,
        XS_LEN_ERR = 2'd1,
        XS_TIMEOUT = 2'd2
    } xfer_status_e;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_POLL = 2'd2,
        PH_DATA = 2'd3
    } xfer_phase_e;

    localparam logic [7:0] CMD_TAG_BYTE = 8'hD4;
    localparam int         HDR_BYTES    = 4;

endpackage

// File: rtl/spi_tpm_hdr_mux.sv
module spi_tpm_hdr_mux
    import spi_tpm_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             is_read,
    input  logic [CNT_W-1:0] cnt_m1,
    input  logic [15:0]      reg_addr,
    input  logic [1:0]       sel,
    output logic [7:0]       hdr_byte
);

    localparam int PAD_W = 7 - CNT_W;

    logic [7:0] first_byte;

    generate
        if (PAD_W > 0) begin : g_pad
            assign first_byte = {is_read, {PAD_W{1'b0}}, cnt_m1};
        end else begin : g_nopad
            assign first_byte = {is_read, cnt_m1};
        end
    endgenerate

    always_comb begin
        case (sel)
            2'd0:    hdr_byte = first_byte;
            2'd1:    hdr_byte = CMD_TAG_BYTE;
            2'd2:    hdr_byte = reg_addr[15:8];
            default: hdr_byte = reg_addr[7:0];
        endcase
    end

endmodule

// File: rtl/spi_tpm_byte_engine.sv
module spi_tpm_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic       byte_done,
    output logic [7:0] rx_byte
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic             active;
        logic             high;
        logic [2:0]       bit_idx;
        logic [DIV_W-1:0] div_cnt;
        logic [7:0]       tx_sh;
        logic [7:0]       rx_sh;
        logic             done;
    } eng_t;

    eng_t eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.active) begin
            if (go) begin
                eng_d.active  = 1'b1;
                eng_d.high    = 1'b0;
                eng_d.bit_idx = '0;
                eng_d.div_cnt = '0;
                eng_d.tx_sh   = tx_byte;
            end
        end else if (eng_q.div_cnt == DIV_W'(HALF_DIV - 1)) begin
            eng_d.div_cnt = '0;
            if (!eng_q.high) begin
                eng_d.high  = 1'b1;
                eng_d.rx_sh = {eng_q.rx_sh[6:0], miso};
            end else begin
                eng_d.high = 1'b0;
                if (eng_q.bit_idx == 3'd7) begin
                    eng_d.active = 1'b0;
                    eng_d.done   = 1'b1;
                end else begin
                    eng_d.bit_idx = eng_q.bit_idx + 3'd1;
                    eng_d.tx_sh   = {eng_q.tx_sh[6:0], 1'b0};
                end
            end
        end else begin
            eng_d.div_cnt = eng_q.div_cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign sclk      = eng_q.active & eng_q.high;
    assign mosi      = eng_q.active & eng_q.tx_sh[7];
    assign byte_done = eng_q.done;
    assign rx_byte   = eng_q.rx_sh;

    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));

    // R10
    go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !eng_q.active);

endmodule

// File: rtl/spi_tpm_fifo_master.sv
module spi_tpm_fifo_master
    import spi_tpm_pkg::*;
#(
    parameter  int MAX_LEN   = 64,
    parameter  int HALF_DIV  = 2,
    parameter  int MAX_POLLS = 100,
    localparam int IDX_W     = $clog2(MAX_LEN),
    localparam int LEN_W     = IDX_W + 1,
    localparam int BUF_W     = MAX_LEN * 8,
    localparam int POLL_W    = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             is_read,
    input  logic [15:0]      addr,
    input  logic [LEN_W-1:0] len,
    input  logic [BUF_W-1:0] wr_data,
    output logic             busy,
    output logic             done,
    output logic [1:0]       status,
    output logic [BUF_W-1:0] rd_data,
    output logic             sclk,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);

    typedef struct packed {
        xfer_phase_e       ph;
        logic              rd;
        logic [15:0]       reg_addr;
        logic [IDX_W-1:0]  cnt_m1;
        logic [IDX_W-1:0]  idx;
        logic [POLL_W-1:0] polls;
        logic [BUF_W-1:0]  wbuf;
        logic [BUF_W-1:0]  rbuf;
        logic              cs_n;
        logic              go;
        logic [7:0]        go_byte;
        logic              done;
        xfer_status_e      status;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic             eng_done;
    logic [7:0]       eng_rx;
    logic [7:0]       hdr_byte;
    logic [IDX_W-1:0] nidx;
    logic             len_bad;
    logic             in_idle;

    assign in_idle = (ctl_q.ph == PH_IDLE);
    assign nidx    = ctl_q.idx + IDX_W'(1);
    assign len_bad = (len == '0) || (len > LEN_W'(MAX_LEN));

    spi_tpm_hdr_mux #(.CNT_W(IDX_W)) u_hdr (
        .is_read  (in_idle ? is_read : ctl_q.rd),
        .cnt_m1   (in_idle ? IDX_W'(len - LEN_W'(1)) : ctl_q.cnt_m1),
        .reg_addr (in_idle ? addr : ctl_q.reg_addr),
        .sel      (in_idle ? 2'd0 : nidx[1:0]),
        .hdr_byte (hdr_byte)
    );

    spi_tpm_byte_engine #(.HALF_DIV(HALF_DIV)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (ctl_q.go),
        .tx_byte   (ctl_q.go_byte),
        .miso      (miso),
        .sclk      (sclk),
        .mosi      (mosi),
        .byte_done (eng_done),
        .rx_byte   (eng_rx)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.go   = 1'b0;
        ctl_d.done = 1'b0;
        case (ctl_q.ph)
            PH_IDLE: begin
                if (start) begin
                    if (len_bad) begin
                        ctl_d.done   = 1'b1;
                        ctl_d.status = XS_LEN_ERR;
                    end else begin
                        ctl_d.ph       = PH_HDR;
                        ctl_d.rd       = is_read;
                        ctl_d.reg_addr = addr;
                        ctl_d.cnt_m1   = IDX_W'(len - LEN_W'(1));
                        ctl_d.wbuf     = wr_data;
                        ctl_d.idx      = '0;
                        ctl_d.polls    = '0;
                        ctl_d.cs_n     = 1'b0;
                        ctl_d.go       = 1'b1;
                        ctl_d.go_byte  = hdr_byte;
                    end
                end
            end
            PH_HDR: begin
                if (eng_done) begin
                    ctl_d.go = 1'b1;
                    if (ctl_q.idx == IDX_W'(HDR_BYTES - 1)) begin
                        ctl_d.ph      = PH_POLL;
                        ctl_d.polls   = '0;
                        ctl_d.go_byte = 8'h00;
                    end else begin
                        ctl_d.idx     = nidx;
                        ctl_d.go_byte = hdr_byte;
                    end
                end
            end
            PH_POLL: begin
                if (eng_done) begin
                    if (eng_rx[0]) begin
                        ctl_d.ph      = PH_DATA;
                        ctl_d.idx     = '0;
                        ctl_d.go      = 1'b1;
                        ctl_d.go_byte = ctl_q.rd ? 8'h00 : ctl_q.wbuf[7:0];
                    end else if (ctl_q.polls == POLL_W'(MAX_POLLS - 1)) begin
                        ctl_d.ph     = PH_IDLE;
                        ctl_d.cs_n   = 1'b1;
                        ctl_d.done   = 1'b1;
                        ctl_d.status = XS_TIMEOUT;
                    end else begin
                        ctl_d.polls   = ctl_q.polls + POLL_W'(1);
                        ctl_d.go      = 1'b1;
                        ctl_d.go_byte = 8'h00;
                    end
                end
            end
            default: begin
                if (eng_done) begin
                    if (ctl_q.rd) begin
                        ctl_d.rbuf[{ctl_q.idx, 3'b000} +: 8] = eng_rx;
                    end
                    if (ctl_q.idx == ctl_q.cnt_m1) begin
                        ctl_d.ph     = PH_IDLE;
                        ctl_d.cs_n   = 1'b1;
                        ctl_d.done   = 1'b1;
                        ctl_d.status = XS_OK;
                    end else begin
                        ctl_d.idx     = nidx;
                        ctl_d.go      = 1'b1;
                        ctl_d.go_byte = ctl_q.rd ? 8'h00 : ctl_q.wbuf[{nidx, 3'b000} +: 8];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q      <= '0;
            ctl_q.cs_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy    = !in_idle;
    assign done    = ctl_q.done;
    assign status  = ctl_q.status;
    assign rd_data = ctl_q.rbuf;
    assign cs_n    = ctl_q.cs_n;

    // R4
    cs_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R4
    sclk_under_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // R3
    len_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((len == '0) || (len > LEN_W'(MAX_LEN))))
            |=> (done && status == XS_LEN_ERR && cs_n));

    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.polls <= POLL_W'(MAX_POLLS - 1));

    // R5
    poll_mosi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_POLL && sclk) |-> !mosi);

endmodule

// File: tb/spi_tpm_fifo_master_tb.sv
module spi_tpm_fifo_master_tb;

    localparam int MAX_LEN   = 64;
    localparam int HALF_DIV  = 2;
    localparam int MAX_POLLS = 8;
    localparam int LEN_W     = 7;
    localparam int BUF_W     = MAX_LEN * 8;

    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  len;
        logic [7:0]  waits;
        logic [1:0]  exp;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h0F90, 8'd4,  8'd0, 2'd0},
        '{1'b0, 16'h0018, 8'd1,  8'd2, 2'd0},
        '{1'b1, 16'h0024, 8'd64, 8'd1, 2'd0},
        '{1'b0, 16'hABCD, 8'd7,  8'd7, 2'd0},
        '{1'b1, 16'h1234, 8'd2,  8'd8, 2'd2},
        '{1'b0, 16'h0001, 8'd0,  8'd0, 2'd1},
        '{1'b1, 16'h0002, 8'd65, 8'd0, 2'd1},
        '{1'b0, 16'h00FF, 8'd64, 8'd3, 2'd0}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             is_read = 1'b0;
    logic [15:0]      addr = '0;
    logic [LEN_W-1:0] len = '0;
    logic [BUF_W-1:0] wr_data = '0;
    logic             busy, done, sclk, cs_n, mosi, miso;
    logic [1:0]       status;
    logic [BUF_W-1:0] rd_data;

    int checks = 0;
    int failures = 0;

    logic [7:0] tgt_tx [256];
    logic [7:0] tgt_rx [1024];
    int tot_rx = 0;
    int rbit = 0;
    logic [7:0] rsh = '0;
    int bitpos = 0;
    int bytep = 0;
    int cs_falls = 0;
    int cs_rises = 0;
    int done_cnt = 0;

    always #5 clk = ~clk;

    spi_tpm_fifo_master #(
        .MAX_LEN(MAX_LEN), .HALF_DIV(HALF_DIV), .MAX_POLLS(MAX_POLLS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_read(is_read),
        .addr(addr), .len(len), .wr_data(wr_data), .busy(busy),
        .done(done), .status(status), .rd_data(rd_data), .sclk(sclk),
        .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    assign miso = tgt_tx[bytep[7:0]][3'(7 - bitpos)];

    always @(negedge cs_n) cs_falls++;
    always @(posedge cs_n) cs_rises++;
    always @(posedge clk) if (done) done_cnt++;

    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            rbit = 0;
        end else begin
            rsh = {rsh[6:0], mosi};
            rbit++;
            if (rbit == 8) begin
                tgt_rx[tot_rx % 1024] = rsh;
                tot_rx++;
                rbit = 0;
            end
        end
    end

    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            bitpos = 0;
            bytep  = 0;
        end else begin
            bitpos++;
            if (bitpos == 8) begin
                bitpos = 0;
                bytep++;
            end
        end
    end

    function automatic logic [7:0] wpat(int k, logic [15:0] a);
        return 8'(k * 7) ^ a[15:8] ^ 8'h3C;
    endfunction

    function automatic logic [7:0] rpat(int k, logic [15:0] a);
        return 8'(k * 29 + int'(a[7:0]) + 5) ^ 8'hA5;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic load_target(input int waits, input logic rd, input logic [15:0] a);
        for (int i = 0; i < 256; i++) tgt_tx[i] = 8'hFF;
        for (int i = 0; i < 4; i++) tgt_tx[i] = 8'h01;
        for (int i = 0; i < waits; i++) tgt_tx[4 + i] = 8'hFE;
        tgt_tx[4 + waits] = 8'h01;
        for (int i = 0; i < MAX_LEN; i++)
            tgt_tx[5 + waits + i] = rd ? rpat(i, a) : 8'hFF;
    endtask

    task automatic pulse_start(input logic rd, input logic [15:0] a, input int n);
        @(negedge clk);
        start   = 1'b1;
        is_read = rd;
        addr    = a;
        len     = LEN_W'(n);
        for (int i = 0; i < MAX_LEN; i++) wr_data[8*i +: 8] = wpat(i, a);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int g = 0;
        while (!done && g < 20000) begin
            @(negedge clk);
            g++;
        end
    endtask

    task automatic run_vec(input vec_t v);
        int rx0 = tot_rx;
        int cf0 = cs_falls;
        int cr0 = cs_rises;
        int npoll, nbytes;
        load_target(int'(v.waits), v.rd, v.addr);
        pulse_start(v.rd, v.addr, int'(v.len));
        if (v.exp != 2'd1) chk(busy === 1'b1, "R10", "busy after start", busy, 1);
        wait_done();
        chk(done === 1'b1 && status === v.exp,
            (v.exp == 2'd1) ? "R3" : (v.exp == 2'd2) ? "R7" : (v.rd ? "R8" : "R9"),
            "status", status, v.exp);
        @(negedge clk);
        if (v.exp == 2'd1) begin
            chk(tot_rx == rx0 && cs_falls == cf0, "R3", "bus activity", tot_rx - rx0, 0);
            return;
        end
        npoll  = (v.exp == 2'd2) ? MAX_POLLS : int'(v.waits) + 1;
        nbytes = 4 + npoll + ((v.exp == 2'd2) ? 0 : int'(v.len));
        chk(tot_rx - rx0 == nbytes, "R6", "bytes clocked", tot_rx - rx0, nbytes);
        chk(cs_falls - cf0 == 1 && cs_rises - cr0 == 1, "R4", "cs edges",
            cs_falls - cf0, 1);
        chk(tgt_rx[rx0 % 1024] == {v.rd, 1'b0, 6'(v.len - 8'd1)}, "R1", "hdr0",
            tgt_rx[rx0 % 1024], {v.rd, 1'b0, 6'(v.len - 8'd1)});
        chk(tgt_rx[(rx0 + 1) % 1024] == 8'hD4, "R2", "hdr1", tgt_rx[(rx0 + 1) % 1024], 8'hD4);
        chk(tgt_rx[(rx0 + 2) % 1024] == v.addr[15:8], "R2", "hdr2",
            tgt_rx[(rx0 + 2) % 1024], v.addr[15:8]);
        chk(tgt_rx[(rx0 + 3) % 1024] == v.addr[7:0], "R2", "hdr3",
            tgt_rx[(rx0 + 3) % 1024], v.addr[7:0]);
        for (int i = 0; i < npoll; i++)
            chk(tgt_rx[(rx0 + 4 + i) % 1024] == 8'h00, "R5", "poll mosi",
                tgt_rx[(rx0 + 4 + i) % 1024], 0);
        if (v.exp == 2'd0) begin
            for (int i = 0; i < int'(v.len); i++) begin
                if (v.rd) begin
                    chk(rd_data[8*i +: 8] == rpat(i, v.addr), "R8", "read byte",
                        rd_data[8*i +: 8], rpat(i, v.addr));
                    chk(tgt_rx[(rx0 + 4 + npoll + i) % 1024] == 8'h00, "R8", "read mosi",
                        tgt_rx[(rx0 + 4 + npoll + i) % 1024], 0);
                end else begin
                    chk(tgt_rx[(rx0 + 4 + npoll + i) % 1024] == wpat(i, v.addr), "R9",
                        "write byte", tgt_rx[(rx0 + 4 + npoll + i) % 1024], wpat(i, v.addr));
                end
            end
        end
    endtask

    task automatic run_all();
        int rx0, dc0;
        repeat (3) @(negedge clk);
        chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0 && done === 1'b0,
            "R11", "reset outputs", {cs_n, sclk, busy, done}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VECS[k]);

        // R10: a second start during an access is ignored
        rx0 = tot_rx;
        dc0 = done_cnt;
        load_target(0, 1'b1, 16'h0042);
        pulse_start(1'b1, 16'h0042, 3);
        repeat (60) @(negedge clk);
        pulse_start(1'b0, 16'h9999, 1);
        wait_done();
        repeat (40) @(negedge clk);
        chk(done_cnt - dc0 == 1, "R10", "done count", done_cnt - dc0, 1);
        chk(tot_rx - rx0 == 8, "R10", "bytes with extra start", tot_rx - rx0, 8);
        chk(tgt_rx[(rx0 + 2) % 1024] == 8'h00 && tgt_rx[(rx0 + 3) % 1024] == 8'h42,
            "R10", "addr kept", tgt_rx[(rx0 + 3) % 1024], 8'h42);
        chk(rd_data[23:0] == {rpat(2, 16'h0042), rpat(1, 16'h0042), rpat(0, 16'h0042)},
            "R8", "read after extra start", rd_data[23:0],
            {rpat(2, 16'h0042), rpat(1, 16'h0042), rpat(0, 16'h0042)});
        chk(busy === 1'b0 && cs_n === 1'b1, "R10", "idle after", {busy, cs_n}, 2'b01);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                failures++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule